// File: doc/BRIEF.md
# Masked Parallel Array Write Unit

This unit turns a write request into the strobes that update one entry of a 72-bit-wide word store. The store is either the data array or the mask array. The unit does not hold the arrays itself. It produces per-partition write enables, an in-partition location, the write word, and a per-bit write mask that the array macros apply.

The per-bit write mask is taken from a bank of global mask registers. A 4-bit index carried in the command picks the register. An array bit is updated only where the chosen register holds a 1; every other bit keeps its stored value.

A parallel mode supports fast initialisation and diagnostics. In this mode one request fans out to every partition at once, and each partition writes an even/odd pair of adjacent entries. With the default sizes, that is 64 words written with the same data and the same bit mask.

All outputs are registered, one cycle after the request. Reserved array-select codes produce no write.

Top module: `mpw_write_unit`

## Requirements
- R1: While reset is asserted and on the first cycles after it, every partition write enable (data and mask) is 0 and the pair flag is 0.
- R2: A request sampled on a rising edge with `i_wr_valid` high drives its enables on the outputs after that same edge, for exactly one cycle. When no request was sampled, all enables are 0.
- R3: The bit mask output equals global mask register number `{i_cmd[10], i_cmd[5:3]}`. Register k occupies bits `[k*72 +: 72]` of `i_gmr_bank`.
- R4: Array select `2'b00` raises only data-array enables. Array select `2'b01` raises only mask-array enables.
- R5: Array select `2'b10` or `2'b11` is reserved and raises no enable of either array.
- R6: With `i_cmd[9]` = 0 (normal mode), exactly one partition enable is raised, the one numbered `i_addr[15:11]`. The location is `i_addr[10:0]` and the pair flag is 0.
- R7: With `i_cmd[9]` = 1 (parallel mode), all 32 partition enables are raised and the pair flag is 1. The location is `{i_addr[10:1], 1'b0}`, so `i_addr[0]` has no effect, and the pair at that even location and the next odd one is written.
- R8: The write word equals the request's `i_wdata`. In both modes one bit mask applies to every enabled partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_wr_valid | input | 1 | Write request strobe |
| i_cmd | input | 11 | Command bits: [10] and [5:3] give the mask index, [9] selects parallel mode |
| i_addr | input | 16 | Array address: [15:11] partition, [10:0] location |
| i_arr_sel | input | 2 | Target array: 00 data, 01 mask, others reserved |
| i_wdata | input | 72 | Word to write |
| i_gmr_bank | input | 1152 | Loaded global mask register bank, 16 x 72 bits |
| o_dat_we | output | 32 | Per-partition write enable, data array |
| o_msk_we | output | 32 | Per-partition write enable, mask array |
| o_pair | output | 1 | Write both the even location and the next odd one |
| o_local_addr | output | 11 | Location inside each enabled partition |
| o_wdata | output | 72 | Registered write word |
| o_bit_mask | output | 72 | Per-bit update mask: 1 = bit is written |

## Verification
The bench uses the default sizes: 72-bit words, 16-bit addresses with 5 partition bits, and 16 global mask registers. At these sizes the full 32-wide parallel fan-out and all 16 mask-register indices can be reached. This covers the index bit taken from above the parallel-mode bit. Partition numbers 0 and 31 exercise both ends of the one-hot decode. An odd address in parallel mode shows that the lowest address bit is dropped.

// File: rtl/mpw_pkg.sv
`timescale 1ns/1ps
package mpw_pkg;

  localparam int CMD_W      = 11;
  localparam int GMR_IDX_W  = 4;
  localparam int PAR_BIT    = 9;

  typedef enum logic [1:0] {
    ARR_DATA  = 2'b00,
    ARR_MASK  = 2'b01,
    ARR_RSV_A = 2'b10,
    ARR_RSV_B = 2'b11
  } arr_sel_e;

  // Mask register index: command bit 10 on top of command bits 5..3.
  function automatic logic [GMR_IDX_W-1:0] gmr_index(input logic [CMD_W-1:0] cmd);
    return {cmd[10], cmd[5:3]};
  endfunction

  function automatic logic is_parallel(input logic [CMD_W-1:0] cmd);
    return cmd[PAR_BIT];
  endfunction

  function automatic logic target_known(input logic [1:0] sel);
    return (sel == ARR_DATA) || (sel == ARR_MASK);
  endfunction

  // In parallel mode the low address bit is dropped so the pair starts even.
  function automatic logic [31:0] local_location(input logic [31:0] loc, input logic par);
    return par ? (loc & ~32'd1) : loc;
  endfunction

endpackage

// File: rtl/mpw_gmr_select.sv
`timescale 1ns/1ps
module mpw_gmr_select #(
  parameter int DATA_W  = 72,
  parameter int NUM_GMR = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_GMR*DATA_W-1:0] i_bank,
  input  logic [IDX_W-1:0]          i_idx,
  output logic [DATA_W-1:0]         o_mask
);

  always_comb begin
    o_mask = '0;
    for (int k = 0; k < NUM_GMR; k++) begin
      if (i_idx == IDX_W'(k)) o_mask = i_bank[k*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/mpw_part_decode.sv
`timescale 1ns/1ps
module mpw_part_decode #(
  parameter int PART_BITS = 5,
  localparam int NUM_PART = 1 << PART_BITS
) (
  input  logic                 i_enable,
  input  logic                 i_parallel,
  input  logic [PART_BITS-1:0] i_part,
  output logic [NUM_PART-1:0]  o_we
);

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    assign o_we[p] = i_enable && (i_parallel || (i_part == PART_BITS'(p)));
  end

endmodule

// File: rtl/mpw_out_stage.sv
`timescale 1ns/1ps
module mpw_out_stage #(
  parameter int DATA_W   = 72,
  parameter int NUM_PART = 32,
  parameter int LOCAL_W  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PART-1:0] i_dat_we,
  input  logic [NUM_PART-1:0] i_msk_we,
  input  logic                i_pair,
  input  logic [LOCAL_W-1:0]  i_loc,
  input  logic [DATA_W-1:0]   i_wdata,
  input  logic [DATA_W-1:0]   i_mask,
  output logic [NUM_PART-1:0] o_dat_we,
  output logic [NUM_PART-1:0] o_msk_we,
  output logic                o_pair,
  output logic [LOCAL_W-1:0]  o_loc,
  output logic [DATA_W-1:0]   o_wdata,
  output logic [DATA_W-1:0]   o_mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_dat_we <= '0;
      o_msk_we <= '0;
      o_pair   <= 1'b0;
      o_loc    <= '0;
      o_wdata  <= '0;
      o_mask   <= '0;
    end else begin
      o_dat_we <= i_dat_we;
      o_msk_we <= i_msk_we;
      o_pair   <= i_pair;
      o_loc    <= i_loc;
      o_wdata  <= i_wdata;
      o_mask   <= i_mask;
    end
  end

endmodule

// File: rtl/mpw_write_unit.sv
`timescale 1ns/1ps
module mpw_write_unit #(
  parameter int DATA_W    = 72,
  parameter int ADDR_W    = 16,
  parameter int PART_BITS = 5,
  parameter int NUM_GMR   = 16,
  localparam int NUM_PART = 1 << PART_BITS,
  localparam int LOCAL_W  = ADDR_W - PART_BITS,
  localparam int IDX_W    = mpw_pkg::GMR_IDX_W,
  localparam int CMD_W    = mpw_pkg::CMD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      i_wr_valid,
  input  logic [CMD_W-1:0]          i_cmd,
  input  logic [ADDR_W-1:0]         i_addr,
  input  logic [1:0]                i_arr_sel,
  input  logic [DATA_W-1:0]         i_wdata,
  input  logic [NUM_GMR*DATA_W-1:0] i_gmr_bank,
  output logic [NUM_PART-1:0]       o_dat_we,
  output logic [NUM_PART-1:0]       o_msk_we,
  output logic                      o_pair,
  output logic [LOCAL_W-1:0]        o_local_addr,
  output logic [DATA_W-1:0]         o_wdata,
  output logic [DATA_W-1:0]         o_bit_mask
);
  import mpw_pkg::*;

  // Named request events, brought out for the checker.
  logic                 req_parallel;
  logic                 req_target_ok;
  logic                 req_go;
  logic [IDX_W-1:0]     req_gmr_idx;
  logic [PART_BITS-1:0] req_part;
  logic [LOCAL_W-1:0]   req_loc;
  logic [DATA_W-1:0]    sel_mask;
  logic [NUM_PART-1:0]  part_we;
  logic [NUM_PART-1:0]  dat_we_n;
  logic [NUM_PART-1:0]  msk_we_n;

  assign req_parallel  = is_parallel(i_cmd);
  assign req_target_ok = target_known(i_arr_sel);
  assign req_go        = i_wr_valid && req_target_ok;
  assign req_gmr_idx   = gmr_index(i_cmd);
  assign req_part      = i_addr[ADDR_W-1 -: PART_BITS];
  assign req_loc       = LOCAL_W'(local_location(32'(i_addr[LOCAL_W-1:0]), req_parallel));

  mpw_gmr_select #(
    .DATA_W (DATA_W),
    .NUM_GMR(NUM_GMR),
    .IDX_W  (IDX_W)
  ) u_gmr (
    .i_bank(i_gmr_bank),
    .i_idx (req_gmr_idx),
    .o_mask(sel_mask)
  );

  mpw_part_decode #(
    .PART_BITS(PART_BITS)
  ) u_dec (
    .i_enable  (req_go),
    .i_parallel(req_parallel),
    .i_part    (req_part),
    .o_we      (part_we)
  );

  assign dat_we_n = (i_arr_sel == ARR_DATA) ? part_we : '0;
  assign msk_we_n = (i_arr_sel == ARR_MASK) ? part_we : '0;

  mpw_out_stage #(
    .DATA_W  (DATA_W),
    .NUM_PART(NUM_PART),
    .LOCAL_W (LOCAL_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_dat_we(dat_we_n),
    .i_msk_we(msk_we_n),
    .i_pair  (req_go && req_parallel),
    .i_loc   (req_loc),
    .i_wdata (i_wdata),
    .i_mask  (sel_mask),
    .o_dat_we(o_dat_we),
    .o_msk_we(o_msk_we),
    .o_pair  (o_pair),
    .o_loc   (o_local_addr),
    .o_wdata (o_wdata),
    .o_mask  (o_bit_mask)
  );

endmodule

// File: rtl/mpw_write_unit_chk.sv
`timescale 1ns/1ps
module mpw_write_unit_chk #(
  parameter int DATA_W   = 72,
  parameter int NUM_PART = 32,
  parameter int LOCAL_W  = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                i_wr_valid,
  input logic [10:0]         i_cmd,
  input logic [1:0]          i_arr_sel,
  input logic [DATA_W-1:0]   i_wdata,
  input logic [NUM_PART-1:0] o_dat_we,
  input logic [NUM_PART-1:0] o_msk_we,
  input logic                o_pair,
  input logic [LOCAL_W-1:0]  o_local_addr,
  input logic [DATA_W-1:0]   o_wdata
);

  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !i_wr_valid |=> (o_dat_we == '0 && o_msk_we == '0 && !o_pair)); // R2

  AST_ONE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !((|o_dat_we) && (|o_msk_we))); // R4

  AST_RSV_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_wr_valid && i_arr_sel[1]) |=> (o_dat_we == '0 && o_msk_we == '0)); // R5

  AST_NORMAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (i_wr_valid && !i_cmd[9] && !i_arr_sel[1])
      |=> ($countones(o_dat_we | o_msk_we) == 1 && !o_pair)); // R6

  AST_PAR_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (i_wr_valid && i_cmd[9] && !i_arr_sel[1])
      |=> ((&(o_dat_we | o_msk_we)) && o_pair && !o_local_addr[0])); // R7

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    i_wr_valid |=> (o_wdata == $past(i_wdata))); // R8

endmodule

bind mpw_write_unit mpw_write_unit_chk #(
  .DATA_W  (DATA_W),
  .NUM_PART(NUM_PART),
  .LOCAL_W (LOCAL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .i_wr_valid  (i_wr_valid),
  .i_cmd       (i_cmd),
  .i_arr_sel   (i_arr_sel),
  .i_wdata     (i_wdata),
  .o_dat_we    (o_dat_we),
  .o_msk_we    (o_msk_we),
  .o_pair      (o_pair),
  .o_local_addr(o_local_addr),
  .o_wdata     (o_wdata)
);

// File: tb/tb_mpw_write_unit.sv
`timescale 1ns/1ps
module tb_mpw_write_unit;

  localparam int DW = 72;
  localparam int NG = 16;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          i_wr_valid = 1'b0;
  logic [10:0]   i_cmd = '0;
  logic [15:0]   i_addr = '0;
  logic [1:0]    i_arr_sel = '0;
  logic [DW-1:0] i_wdata = '0;
  logic [NG*DW-1:0] bank;
  logic [NP-1:0] o_dat_we, o_msk_we;
  logic          o_pair;
  logic [10:0]   o_local_addr;
  logic [DW-1:0] o_wdata, o_bit_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mpw_write_unit dut (
    .clk(clk), .rst_n(rst_n), .i_wr_valid(i_wr_valid), .i_cmd(i_cmd),
    .i_addr(i_addr), .i_arr_sel(i_arr_sel), .i_wdata(i_wdata),
    .i_gmr_bank(bank), .o_dat_we(o_dat_we), .o_msk_we(o_msk_we),
    .o_pair(o_pair), .o_local_addr(o_local_addr), .o_wdata(o_wdata),
    .o_bit_mask(o_bit_mask)
  );

  function automatic logic [DW-1:0] gm_val(input int k);
    return {18{4'(k)}} ^ {9{8'(8'h5A + k * 3)}};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge; return at the next falling edge,
  // when the registered result is on the outputs.
  task automatic send(input logic [10:0] cmd, input logic [15:0] addr,
                      input logic [1:0] sel, input logic [DW-1:0] data);
    @(negedge clk);
    i_wr_valid = 1'b1; i_cmd = cmd; i_addr = addr; i_arr_sel = sel; i_wdata = data;
    @(negedge clk);
    i_wr_valid = 1'b0;
  endtask

  function automatic logic [10:0] mk_cmd(input int idx, input logic par);
    logic [10:0] c;
    c = 11'h000;
    c[10]  = idx[3];
    c[5:3] = idx[2:0];
    c[9]   = par;
    return c;
  endfunction

  task automatic t_reset;
    chk("R1", "dat_we in reset", DW'(o_dat_we), '0);
    chk("R1", "msk_we in reset", DW'(o_msk_we), '0);
    chk("R1", "pair in reset", DW'(o_pair), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dat_we after reset", DW'(o_dat_we), '0);
    chk("R1", "msk_we after reset", DW'(o_msk_we), '0);
  endtask

  task automatic t_normal(input logic [1:0] sel, input int part, input int loc, input int idx);
    logic [15:0] a;
    logic [DW-1:0] d;
    logic [NP-1:0] one;
    a = {5'(part), 11'(loc)};
    d = {8'(part), 64'hC0DE_0000_0000_0000 + 64'(loc)};
    one = NP'(1) << part;
    send(mk_cmd(idx, 1'b0), a, sel, d);
    chk("R6", "normal dat_we", DW'(o_dat_we), sel == 2'b00 ? DW'(one) : '0);
    chk("R4", "normal msk_we", DW'(o_msk_we), sel == 2'b01 ? DW'(one) : '0);
    chk("R6", "normal location", DW'(o_local_addr), DW'(loc));
    chk("R6", "normal pair", DW'(o_pair), '0);
    chk("R3", "normal bit mask", o_bit_mask, gm_val(idx));
    chk("R8", "normal wdata", o_wdata, d);
  endtask

  task automatic t_parallel(input logic [1:0] sel, input int loc, input int idx);
    logic [15:0] a;
    logic [DW-1:0] d;
    a = {5'd17, 11'(loc)};
    d = {DW{1'b1}} ^ DW'(loc);
    send(mk_cmd(idx, 1'b1), a, sel, d);
    chk("R7", "par dat_we", DW'(o_dat_we), sel == 2'b00 ? DW'({NP{1'b1}}) : '0);
    chk("R7", "par msk_we", DW'(o_msk_we), sel == 2'b01 ? DW'({NP{1'b1}}) : '0);
    chk("R7", "par pair", DW'(o_pair), DW'(1));
    chk("R7", "par location even", DW'(o_local_addr), DW'(loc & 32'h7FE));
    chk("R8", "par shared bit mask", o_bit_mask, gm_val(idx));
    chk("R8", "par wdata", o_wdata, d);
  endtask

  task automatic t_reserved(input logic [1:0] sel, input logic par);
    send(mk_cmd(2, par), 16'hFFFF, sel, '1);
    chk("R5", "reserved dat_we", DW'(o_dat_we), '0);
    chk("R5", "reserved msk_we", DW'(o_msk_we), '0);
  endtask

  task automatic t_one_cycle;
    send(mk_cmd(0, 1'b0), 16'h0800, 2'b00, 72'h1);
    chk("R2", "pulse present", DW'(o_dat_we), DW'(NP'(2)));
    @(negedge clk);
    chk("R2", "pulse gone", DW'(o_dat_we), '0);
    chk("R2", "pair idle", DW'(o_pair), '0);
  endtask

  task automatic t_index_sweep;
    for (int k = 0; k < NG; k++) begin
      send(mk_cmd(k, 1'b0), 16'(k), 2'b00, DW'(k));
      chk("R3", $sformatf("mask index %0d", k), o_bit_mask, gm_val(k));
    end
  endtask

  initial begin
    for (int k = 0; k < NG; k++) bank[k*DW +: DW] = gm_val(k);
    repeat (3) @(negedge clk);
    t_reset();
    t_normal(2'b00, 0, 0, 0);
    t_normal(2'b00, 31, 11'h7FF, 9);
    t_normal(2'b01, 13, 11'h2A5, 15);
    t_parallel(2'b00, 11'h3C5, 8);
    t_parallel(2'b01, 11'h3C4, 7);
    t_parallel(2'b00, 11'h001, 12);
    t_reserved(2'b10, 1'b0);
    t_reserved(2'b11, 1'b1);
    t_one_cycle();
    t_index_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule